// File: doc/BRIEF.md
# DDR3 Power-Up Initialization Sequencer

This block brings a DDR3 memory out of power-up. It runs a short script in which every step does one of two things. It either places one command on the memory command bus, or it starts a wait of a fixed number of fabric clocks. Each step also sets the levels of the memory reset pin and the clock-enable pin. One step is marked as the last. When the script reaches it, the sequencer raises its done flag and gives the command bus to the controller that sits upstream.

A single down-counter paces the script. Each time the counter expires, the script index moves forward by one step. Until the done flag rises, the upstream command port is ignored completely. Every cycle in which the script places no command carries a no-op with zero bank and address. A synchronous reset can arrive at any time, and it restarts the whole script.

Top module: `ddr3_init_seq`

## Requirements
- R1: While reset is asserted, and on the cycle after each reset edge, the outputs are: memory reset low, CKE low, done low, and command no-op. The command field is {CS,RAS,CAS,WE} = 0111, with bank 0 and address 0.
- R2: Count edges from the first rising edge with reset low, which is edge 1. The first script step takes effect on edge 3. A step that waits W clocks makes the next step take effect W+1 edges later, and any other step makes it take effect 1 edge later. The memory reset pin rises on edge 40004, which is the end of a 40,000-clock hold, and stays high.
- R3: CKE rises on edge 140005, after a further 100,000-clock wait with reset high, and stays high.
- R4: Mode-register writes (command 0000) occur in three places. The first is on edge 140074 (after a 68-clock wait), with bank 2 and address 0x0040. The second is on edge 140076, with bank 1 and address 0x0044. The third is on edge 140078, with bank 0 and address 0x0420.
- R5: A 10-clock wait follows the last mode write. Long ZQ calibration (command 0110) is then issued on edge 140090, with bank 0 and address 0x0400 (bit 10 set).
- R6: A 254-clock wait follows the calibration. Precharge-all (command 0010, bank 0, address 0x0400) is issued on edge 140346. After a 1-clock wait, one refresh (command 0001, bank 0, address 0) is issued on edge 140349.
- R7: After a 30-clock wait, done rises on edge 140381 and stays high until the next reset. Memory reset and CKE stay high.
- R8: Each scripted command lasts exactly one cycle. Every other cycle before done drives no-op with bank 0 and address 0.
- R9: Before done, the upstream command, bank and address inputs have no effect on the outputs. From done on, the outputs equal those inputs within the same cycle.
- R10: A reset asserted in the middle of a wait, or after done, returns the outputs to the R1 state. Once reset is released, the full schedule of R2 to R7 repeats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock (200 MHz) |
| rst | input | 1 | Synchronous active-high reset |
| host_cmd | input | 4 | Upstream {CS,RAS,CAS,WE} command |
| host_bank | input | 3 | Upstream bank select |
| host_addr | input | 14 | Upstream row/column address |
| mem_reset_n | output | 1 | Memory reset pin, active low |
| mem_cke | output | 1 | Memory clock enable |
| mem_cmd | output | 4 | {CS,RAS,CAS,WE} to memory |
| mem_bank | output | 3 | Bank select to memory |
| mem_addr | output | 14 | Address to memory |
| init_done | output | 1 | Script finished; command bus belongs to the upstream port |

## Verification
The reference model places every step on an absolute edge number. An off-by-one in the expiry of the timer or the load value therefore shows up as a reset_n, CKE or mode-write edge that is one cycle early or late. The upstream inputs change at random in every cycle, including read, write and activate codes. A mux that leaks them before done, or one that fails to hand over after done, produces a command mismatch. Resets are applied in the middle of the first hold and after completion. A sequencer that fails to reload its boot delay or restart its index would resume mid-script or stay done.

// File: rtl/ddr3_init_pkg.sv
package ddr3_init_pkg;

    localparam int CMD_W  = 4;
    localparam int BANK_W = 3;
    localparam int ADDR_W = 14;
    localparam int OPND_W = BANK_W + ADDR_W;
    localparam int IDX_W  = 5;

    typedef enum logic [CMD_W-1:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_RD  = 4'b0101,
        CMD_ZQ  = 4'b0110,
        CMD_NOP = 4'b0111
    } dram_cmd_e;

    // One script step: flags, command, operand (bank+address or wait count)
    typedef struct packed {
        logic                  last;
        logic                  wait_en;
        logic                  rst_lvl;
        logic                  cke_lvl;
        dram_cmd_e             cmd;
        logic [OPND_W-1:0]     opnd;
    } step_t;

    typedef struct packed {
        dram_cmd_e             cmd;
        logic [BANK_W-1:0]     bank;
        logic [ADDR_W-1:0]     addr;
    } cmd_word_t;

    localparam logic [ADDR_W-1:0] MODE0_VAL = 14'h0420;
    localparam logic [ADDR_W-1:0] MODE1_VAL = 14'h0044;
    localparam logic [ADDR_W-1:0] MODE2_VAL = 14'h0040;
    localparam logic [ADDR_W-1:0] ADDR_A10  = 14'h0400;

    localparam cmd_word_t IDLE_WORD = '{cmd: CMD_NOP, bank: '0, addr: '0};

    function automatic step_t mk_step(
        input logic last, input logic wait_en,
        input logic rst_lvl, input logic cke_lvl,
        input dram_cmd_e cmd, input logic [OPND_W-1:0] opnd);
        step_t s;
        s.last    = last;
        s.wait_en = wait_en;
        s.rst_lvl = rst_lvl;
        s.cke_lvl = cke_lvl;
        s.cmd     = cmd;
        s.opnd    = opnd;
        return s;
    endfunction

    function automatic logic [OPND_W-1:0] bank_addr(
        input logic [BANK_W-1:0] bank, input logic [ADDR_W-1:0] addr);
        return {bank, addr};
    endfunction

endpackage

// File: rtl/init_script_rom.sv
module init_script_rom
    import ddr3_init_pkg::*;
#(
    parameter int T_RST_HOLD = 40000,
    parameter int T_CKE_HOLD = 100000,
    parameter int T_XPR      = 68,
    parameter int T_MOD      = 10,
    parameter int T_ZQINIT   = 254,
    parameter int T_RP       = 1,
    parameter int T_RFC      = 30
) (
    input  logic [IDX_W-1:0] idx,
    output step_t            step
);
    localparam logic [OPND_W-1:0] NO_OPND = '0;

    always_comb begin
        case (idx)
            5'd0:  step = mk_step(1'b0, 1'b1, 1'b0, 1'b0, CMD_NOP, OPND_W'(T_RST_HOLD));
            5'd1:  step = mk_step(1'b0, 1'b1, 1'b1, 1'b0, CMD_NOP, OPND_W'(T_CKE_HOLD));
            5'd2:  step = mk_step(1'b0, 1'b1, 1'b1, 1'b1, CMD_NOP, OPND_W'(T_XPR));
            5'd3:  step = mk_step(1'b0, 1'b0, 1'b1, 1'b1, CMD_MRS, bank_addr(3'd2, MODE2_VAL));
            5'd4:  step = mk_step(1'b0, 1'b0, 1'b1, 1'b1, CMD_NOP, NO_OPND);
            5'd5:  step = mk_step(1'b0, 1'b0, 1'b1, 1'b1, CMD_MRS, bank_addr(3'd1, MODE1_VAL));
            5'd6:  step = mk_step(1'b0, 1'b0, 1'b1, 1'b1, CMD_NOP, NO_OPND);
            5'd7:  step = mk_step(1'b0, 1'b0, 1'b1, 1'b1, CMD_MRS, bank_addr(3'd0, MODE0_VAL));
            5'd8:  step = mk_step(1'b0, 1'b1, 1'b1, 1'b1, CMD_NOP, OPND_W'(T_MOD));
            5'd9:  step = mk_step(1'b0, 1'b0, 1'b1, 1'b1, CMD_ZQ,  bank_addr(3'd0, ADDR_A10));
            5'd10: step = mk_step(1'b0, 1'b1, 1'b1, 1'b1, CMD_NOP, OPND_W'(T_ZQINIT));
            5'd11: step = mk_step(1'b0, 1'b0, 1'b1, 1'b1, CMD_PRE, bank_addr(3'd0, ADDR_A10));
            5'd12: step = mk_step(1'b0, 1'b1, 1'b1, 1'b1, CMD_NOP, OPND_W'(T_RP));
            5'd13: step = mk_step(1'b0, 1'b0, 1'b1, 1'b1, CMD_REF, NO_OPND);
            5'd14: step = mk_step(1'b0, 1'b1, 1'b1, 1'b1, CMD_NOP, OPND_W'(T_RFC));
            default: step = mk_step(1'b1, 1'b0, 1'b1, 1'b1, CMD_NOP, NO_OPND);
        endcase
    end
endmodule

// File: rtl/init_wait_timer.sv
module init_wait_timer
    import ddr3_init_pkg::*;
#(
    parameter int CNT_W      = OPND_W,
    parameter int BOOT_DELAY = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= CNT_W'(BOOT_DELAY);
            expired <= 1'b0;
        end else if (!expired) begin
            cnt     <= cnt - ONE;
            expired <= (cnt == ONE);
        end else if (load) begin
            cnt     <= load_val;
            expired <= (load_val == '0);
        end
    end
endmodule

// File: rtl/init_cmd_arbiter.sv
module init_cmd_arbiter
    import ddr3_init_pkg::*;
(
    input  logic              owned,
    input  cmd_word_t         script_word,
    input  logic [CMD_W-1:0]  host_cmd,
    input  logic [BANK_W-1:0] host_bank,
    input  logic [ADDR_W-1:0] host_addr,
    output logic [CMD_W-1:0]  out_cmd,
    output logic [BANK_W-1:0] out_bank,
    output logic [ADDR_W-1:0] out_addr
);
    always_comb begin
        if (owned) begin
            out_cmd  = script_word.cmd;
            out_bank = script_word.bank;
            out_addr = script_word.addr;
        end else begin
            out_cmd  = host_cmd;
            out_bank = host_bank;
            out_addr = host_addr;
        end
    end
endmodule

// File: rtl/ddr3_init_seq.sv
module ddr3_init_seq
    import ddr3_init_pkg::*;
#(
    parameter int T_BOOT     = 2,
    parameter int T_RST_HOLD = 40000,
    parameter int T_CKE_HOLD = 100000,
    parameter int T_XPR      = 68,
    parameter int T_MOD      = 10,
    parameter int T_ZQINIT   = 254,
    parameter int T_RP       = 1,
    parameter int T_RFC      = 30
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CMD_W-1:0]  host_cmd,
    input  logic [BANK_W-1:0] host_bank,
    input  logic [ADDR_W-1:0] host_addr,
    output logic              mem_reset_n,
    output logic              mem_cke,
    output logic [CMD_W-1:0]  mem_cmd,
    output logic [BANK_W-1:0] mem_bank,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              init_done
);
    localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);

    logic [IDX_W-1:0] idx;
    step_t            cur;
    logic             tick;
    logic             owned;
    logic             advance;
    cmd_word_t        script_word;

    init_script_rom #(
        .T_RST_HOLD (T_RST_HOLD),
        .T_CKE_HOLD (T_CKE_HOLD),
        .T_XPR      (T_XPR),
        .T_MOD      (T_MOD),
        .T_ZQINIT   (T_ZQINIT),
        .T_RP       (T_RP),
        .T_RFC      (T_RFC)
    ) u_rom (
        .idx  (idx),
        .step (cur)
    );

    assign advance = tick && owned;

    init_wait_timer #(
        .CNT_W      (OPND_W),
        .BOOT_DELAY (T_BOOT)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (advance && cur.wait_en),
        .load_val (cur.opnd),
        .expired  (tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            idx         <= '0;
            owned       <= 1'b1;
            mem_reset_n <= 1'b0;
            mem_cke     <= 1'b0;
            script_word <= IDLE_WORD;
        end else begin
            script_word <= IDLE_WORD;
            if (advance) begin
                mem_reset_n <= cur.rst_lvl;
                mem_cke     <= cur.cke_lvl;
                if (cur.cmd != CMD_NOP)
                    script_word <= cur;
                if (cur.last)
                    owned <= 1'b0;
                else
                    idx <= idx + IDX_ONE;
            end
        end
    end

    init_cmd_arbiter u_arb (
        .owned       (owned),
        .script_word (script_word),
        .host_cmd    (host_cmd),
        .host_bank   (host_bank),
        .host_addr   (host_addr),
        .out_cmd     (mem_cmd),
        .out_bank    (mem_bank),
        .out_addr    (mem_addr)
    );

    assign init_done = !owned;
endmodule

// File: rtl/ddr3_init_seq_chk.sv
module ddr3_init_seq_chk
    import ddr3_init_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [CMD_W-1:0]  mem_cmd,
    input logic [BANK_W-1:0] mem_bank,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_reset_n,
    input logic              mem_cke,
    input logic              init_done
);
    localparam logic [CMD_W-1:0] NOP = 4'b0111;

    // R1
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!mem_reset_n && !mem_cke && !init_done && mem_cmd == NOP
                 && mem_bank == '0 && mem_addr == '0));

    // R2
    a_r2_reset_pin_holds: assert property (@(posedge clk) disable iff (rst)
        mem_reset_n |=> mem_reset_n);

    // R3
    a_r3_cke_after_reset: assert property (@(posedge clk) disable iff (rst)
        mem_cke |-> mem_reset_n);

    // R7
    a_r7_done_sticky: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

    a_r7_done_needs_pins: assert property (@(posedge clk) disable iff (rst)
        init_done |-> (mem_reset_n && mem_cke));

    // R8
    a_r8_one_cycle_cmd: assert property (@(posedge clk) disable iff (rst)
        (!init_done && mem_cmd != NOP) |=> (init_done || mem_cmd == NOP));

    a_r8_idle_zero: assert property (@(posedge clk) disable iff (rst)
        (!init_done && mem_cmd == NOP) |-> (mem_bank == '0 && mem_addr == '0));

    // R9
    a_r9_no_traffic_in_init: assert property (@(posedge clk) disable iff (rst)
        !init_done |-> (mem_cmd == 4'b0000 || mem_cmd == 4'b0001 ||
                        mem_cmd == 4'b0010 || mem_cmd == 4'b0110 || mem_cmd == NOP));
endmodule

bind ddr3_init_seq ddr3_init_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .mem_cmd     (mem_cmd),
    .mem_bank    (mem_bank),
    .mem_addr    (mem_addr),
    .mem_reset_n (mem_reset_n),
    .mem_cke     (mem_cke),
    .init_done   (init_done)
);

// File: tb/tb_ddr3_init_seq.sv
`timescale 1ns/100ps
module tb_ddr3_init_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  host_cmd  = 4'h7;
    logic [2:0]  host_bank = 3'h0;
    logic [13:0] host_addr = 14'h0;
    logic        mem_reset_n, mem_cke, init_done;
    logic [3:0]  mem_cmd;
    logic [2:0]  mem_bank;
    logic [13:0] mem_addr;

    always #2.5 clk = ~clk;

    ddr3_init_seq dut (
        .clk(clk), .rst(rst),
        .host_cmd(host_cmd), .host_bank(host_bank), .host_addr(host_addr),
        .mem_reset_n(mem_reset_n), .mem_cke(mem_cke),
        .mem_cmd(mem_cmd), .mem_bank(mem_bank), .mem_addr(mem_addr),
        .init_done(init_done)
    );

    int n = 0;               // edges since reset release
    always @(posedge clk) begin
        if (rst) n <= 0;
        else     n <= n + 1;
    end

    int compared   = 0;
    int mismatched = 0;
    bit restarted  = 0;

    // Step schedule from R2..R7: wait lengths per step, commands per step
    int wait_len [16] = '{40000, 100000, 68, 0, 0, 0, 0, 0, 10, 0, 254, 0, 1, 0, 30, 0};
    int step_edge[16];
    int step_cmd [16];
    int step_bank[16];
    int step_addr[16];

    function automatic string tag(input string r);
        return restarted ? {"R10/", r} : r;
    endfunction

    task automatic report(input string r, input string what, input int act, input int exp);
        mismatched++;
        $display("FAIL %s %s at edge %0d: actual %0h expected %0h", tag(r), what, n, act, exp);
    endtask

    task automatic check_cycle();
        bit exp_rn, exp_ck, exp_done;
        int exp_cmd, exp_bank, exp_addr;
        string rc;
        compared++;
        if (n == 0) begin
            exp_rn = 0; exp_ck = 0; exp_done = 0;
            exp_cmd = 7; exp_bank = 0; exp_addr = 0;
            if (mem_reset_n !== 1'b0 || mem_cke !== 1'b0 || init_done !== 1'b0 ||
                mem_cmd !== 4'h7 || mem_bank !== 3'h0 || mem_addr !== 14'h0)
                report("R1", "reset state",
                       {mem_reset_n, mem_cke, init_done, mem_cmd, mem_bank, mem_addr},
                       {3'b000, 4'h7, 3'h0, 14'h0});
            return;
        end
        exp_rn   = (n >= step_edge[1]);
        exp_ck   = (n >= step_edge[2]);
        exp_done = (n >= step_edge[15]);
        exp_cmd = 7; exp_bank = 0; exp_addr = 0; rc = "R8";
        if (exp_done) begin
            exp_cmd = host_cmd; exp_bank = host_bank; exp_addr = host_addr; rc = "R9";
        end else begin
            for (int i = 0; i < 16; i++)
                if (step_edge[i] == n && step_cmd[i] != 7) begin
                    exp_cmd = step_cmd[i]; exp_bank = step_bank[i]; exp_addr = step_addr[i];
                    rc = (i <= 7) ? "R4" : (i == 9) ? "R5" : "R6";
                end
        end
        if (mem_reset_n !== exp_rn) report("R2", "mem_reset_n", mem_reset_n, exp_rn);
        if (mem_cke !== exp_ck)     report("R3", "mem_cke", mem_cke, exp_ck);
        if (init_done !== exp_done) report("R7", "init_done", init_done, exp_done);
        if (mem_cmd !== 4'(exp_cmd) || mem_bank !== 3'(exp_bank) || mem_addr !== 14'(exp_addr))
            report(rc, "cmd/bank/addr", {mem_cmd, mem_bank, mem_addr},
                   {4'(exp_cmd), 3'(exp_bank), 14'(exp_addr)});
    endtask

    task automatic cycle(input bit next_rst);
        @(negedge clk);
        check_cycle();
        #1;
        rst = next_rst;
        host_cmd  = 4'($urandom);   // includes read/write/activate codes (R9)
        host_bank = 3'($urandom);
        host_addr = 14'($urandom);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            step_cmd[i] = 7; step_bank[i] = 0; step_addr[i] = 0;
        end
        step_cmd[3]  = 0; step_bank[3] = 2; step_addr[3] = 'h0040;
        step_cmd[5]  = 0; step_bank[5] = 1; step_addr[5] = 'h0044;
        step_cmd[7]  = 0; step_bank[7] = 0; step_addr[7] = 'h0420;
        step_cmd[9]  = 6; step_addr[9]  = 'h0400;
        step_cmd[11] = 2; step_addr[11] = 'h0400;
        step_cmd[13] = 1;
        step_edge[0] = 3;
        for (int i = 1; i < 16; i++)
            step_edge[i] = step_edge[i-1] + 1 + wait_len[i-1];
        // cross-check the derived schedule against the literal edges of R2..R7
        compared++;
        if (step_edge[1] != 40004 || step_edge[2] != 140005 || step_edge[3] != 140074 ||
            step_edge[9] != 140090 || step_edge[11] != 140346 || step_edge[15] != 140381)
            report("R2", "schedule", step_edge[15], 140381);

        // R1: hold reset
        for (int i = 0; i < 4; i++) cycle(1'b1);
        cycle(1'b0);
        for (int i = 0; i < 50; i++) cycle(1'b0);
        // R10: reset in the middle of the first hold
        restarted = 1;
        cycle(1'b1);
        cycle(1'b1);
        cycle(1'b0);
        while (n < step_edge[15] + 60) cycle(1'b0);
        // R10: reset after done, then the script restarts
        cycle(1'b1);
        cycle(1'b1);
        cycle(1'b1);
        cycle(1'b0);
        for (int i = 0; i < 80; i++) cycle(1'b0);
        summary();
    end

    initial begin
        #(5.0 * 190000);
        mismatched++;
        $display("FAIL watchdog: run did not finish, actual edge %0d expected end", n);
        summary();
    end
endmodule